// File: doc/BRIEF.md
# Host Register Slave Access Controller

This block lets an external host read and write a device's internal registers over a strobe-style interface. The host drives a chip select, an address strobe, a direction line, a register address and write data. All host lines are active-low strobes plus levels, and the block samples them on the rising edge of its bus clock, called the sampling edge below. An access starts on a sampling edge where chip select and address strobe are both seen low. At that edge the block captures the address and the direction. It then signals a start acknowledge, drives read data or produces a one-cycle write strobe toward a register file, and finally pulls both lines of a two-line size acknowledge low, which a host reads as a 32-bit port. The register data path itself is 16 bits wide.

The device may itself be master of the system bus when the host arrives. In that case the block raises a yield request to the device's own master engine. It waits until the engine reports that the bus is free, which the engine does after finishing its current cycle and any wait states, and only then proceeds. The host can keep chip select low and mark several accesses with address-strobe pulses alone. After chip select is released, the block ignores requests for one clock before it accepts a new access.

Top module: `hostreg_slave`

## Requirements
- R1: While reset is applied and after it is released, start_ack_n is 1, dsize_oe is 0, rdata_oe is 0, reg_wr_en is 0 and mst_yield_req is 0 until an access starts.
- R2: reg_addr and the read/write direction (rd_nwr = 1 means read) are taken from the addr and rd_nwr pins at the sampling edge where the access starts. Later changes on those pins do not affect the access.
- R3: When mst_own is 0 at the starting edge, start_ack_n goes low after the next sampling edge, one clock after the start.
- R4: When mst_own is 1 at the starting edge, mst_yield_req is 1 from that edge until the first sampling edge where mst_free is seen high, and start_ack_n stays high throughout. start_ack_n goes low one clock after that edge. With an engine that frees the bus within W+3 clocks (W wait states), this is at most 5+W clocks after the start.
- R5: On a read, rdata_oe is 1 and rdata equals the register file word at the captured address from the cycle in which start_ack_n first goes low, for as long as as_n stays low.
- R6: On a write, reg_wr_en is 1 for exactly one cycle, the second cycle of the start acknowledge, with reg_addr at the captured address and reg_wdata equal to wdata. The register file therefore latches the data on the sampling edge two clocks after start_ack_n falls. On a read, reg_wr_en stays 0.
- R7: Both bits of dsize_ack_n go low together two clocks after start_ack_n falls, and the two bits are always equal.
- R8: dsize_ack_n returns to 2'b11 at once when either cs_n or as_n rises, whichever is first.
- R9: rdata_oe drops at once when as_n rises. On the first sampling edge where as_n is seen high, start_ack_n returns to 1 and dsize_oe to 0.
- R10: No access starts while only one of cs_n and as_n is low: start_ack_n stays 1 and reg_wr_en stays 0.
- R11: With cs_n held low, each new low pulse of as_n starts a new access with the same timing as R3.
- R12: When an access ends with cs_n high, a request driven immediately afterwards is ignored for one sampling edge. start_ack_n then falls one clock later than in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; rising edge is the sampling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Host chip select, active low |
| as_n | input | 1 | Host address strobe, active low |
| rd_nwr | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W | Host register address |
| wdata | input | DATA_W | Host write data |
| start_ack_n | output | 1 | Start acknowledge, active low |
| dsize_ack_n | output | 2 | Size/termination acknowledge pair, active low |
| dsize_oe | output | 1 | Drive enable for dsize_ack_n (0 = high impedance) |
| rdata | output | DATA_W | Read data toward the host |
| rdata_oe | output | 1 | Drive enable for rdata |
| reg_addr | output | ADDR_W | Captured register address to the register file |
| reg_wr_en | output | 1 | One-cycle write strobe to the register file |
| reg_wdata | output | DATA_W | Write data to the register file |
| reg_rdata | input | DATA_W | Read data from the register file |
| mst_own | input | 1 | Device currently owns the system bus |
| mst_free | input | 1 | Master engine has finished its cycle and released the bus |
| mst_yield_req | output | 1 | Request to the master engine to give up the bus |

## Verification
The checker holds on every cycle the relations between the acknowledge outputs. The two size bits always match, and a size acknowledge only appears while both host strobes are low and the start acknowledge is active. Read data is enabled only under a low address strobe. The write strobe falls in the second acknowledge cycle, and the yield request never overlaps the start acknowledge. The exact latencies can only be shown by the bench scenarios: the one-clock start, the stretched start behind a bus-master cycle with wait states, and the extra clock after chip select is released. The same holds for captured values surviving later pin changes, multi-access bursts under a held chip select, and the order in which chip select and address strobe rise.

// File: rtl/hostreg_pkg.sv
`timescale 1ns/1ps
package hostreg_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_YIELD = 3'd1,
    S_SETUP = 3'd2,
    S_ACK_A = 3'd3,
    S_ACK_B = 3'd4,
    S_HOLD  = 3'd5,
    S_GAP   = 3'd6
  } seq_state_t;
endpackage

// File: rtl/hostreg_rst_sync.sv
`timescale 1ns/1ps
module hostreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/hostreg_capture.sv
`timescale 1ns/1ps
module hostreg_capture #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_q
);
  logic [ADDR_W-1:0] addr_d;
  logic              rd_d;

  always_comb begin
    addr_d = addr_q;
    rd_d   = rd_q;
    if (cap_en) begin
      addr_d = addr_in;
      rd_d   = rd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/hostreg_seq.sv
`timescale 1ns/1ps
module hostreg_seq
  import hostreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic as_n,
  input  logic mst_own,
  input  logic mst_free,
  output logic cap_en,
  output logic ack_on,
  output logic wr_slot,
  output logic hold_st,
  output logic yield_on
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (!cs_n && !as_n) begin
          cap_en = 1'b1;
          st_d   = mst_own ? S_YIELD : S_SETUP;
        end
      end
      S_YIELD: if (mst_free) st_d = S_SETUP;
      S_SETUP: st_d = S_ACK_A;
      S_ACK_A: st_d = S_ACK_B;
      S_ACK_B: st_d = S_HOLD;
      S_HOLD:  if (as_n) st_d = cs_n ? S_GAP : S_IDLE;
      S_GAP:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign ack_on   = (st_q == S_ACK_A) || (st_q == S_ACK_B) || (st_q == S_HOLD);
  assign wr_slot  = (st_q == S_ACK_B);
  assign hold_st  = (st_q == S_HOLD);
  assign yield_on = (st_q == S_YIELD);
endmodule

// File: rtl/hostreg_slave.sv
`timescale 1ns/1ps
module hostreg_slave #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              as_n,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              start_ack_n,
  output logic [1:0]        dsize_ack_n,
  output logic              dsize_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              mst_own,
  input  logic              mst_free,
  output logic              mst_yield_req
);
  logic rst_core_n;
  logic cap_en, ack_on, wr_slot, hold_st, yield_on;
  logic rd_q;
  logic size_on;

  hostreg_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  hostreg_seq seq_i (
    .clk(clk), .rst_n(rst_core_n), .cs_n(cs_n), .as_n(as_n),
    .mst_own(mst_own), .mst_free(mst_free),
    .cap_en(cap_en), .ack_on(ack_on), .wr_slot(wr_slot),
    .hold_st(hold_st), .yield_on(yield_on)
  );

  hostreg_capture #(.ADDR_W(ADDR_W)) cap_i (
    .clk(clk), .rst_n(rst_core_n), .cap_en(cap_en),
    .addr_in(addr), .rd_in(rd_nwr), .addr_q(reg_addr), .rd_q(rd_q)
  );

  // size acknowledge is released by whichever host strobe rises first
  assign size_on       = hold_st && !cs_n && !as_n;
  assign dsize_ack_n   = {2{~size_on}};
  assign dsize_oe      = ack_on;
  assign start_ack_n   = ~ack_on;
  assign rdata_oe      = ack_on && rd_q && !as_n;
  assign rdata         = reg_rdata;
  assign reg_wr_en     = wr_slot && !rd_q;
  assign reg_wdata     = wdata;
  assign mst_yield_req = yield_on;
endmodule

// File: rtl/hostreg_chk.sv
`timescale 1ns/1ps
module hostreg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       as_n,
  input logic       start_ack_n,
  input logic [1:0] dsize_ack_n,
  input logic       dsize_oe,
  input logic       rdata_oe,
  input logic       reg_wr_en,
  input logic       mst_yield_req
);
  // R7
  dsize_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsize_ack_n[0] == dsize_ack_n[1]);

  // R8
  dsize_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dsize_ack_n[0] |-> (!cs_n && !as_n && !start_ack_n && dsize_oe));

  // R5
  rdata_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!as_n && !start_ack_n));

  // R6
  wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (!start_ack_n && $past(!start_ack_n) && dsize_ack_n == 2'b11));

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R4
  yield_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_yield_req |-> start_ack_n);
endmodule

bind hostreg_slave hostreg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n),
  .start_ack_n(start_ack_n), .dsize_ack_n(dsize_ack_n), .dsize_oe(dsize_oe),
  .rdata_oe(rdata_oe), .reg_wr_en(reg_wr_en), .mst_yield_req(mst_yield_req)
);

// File: tb/hostreg_slave_tb_top.sv
`timescale 1ns/1ps
module hostreg_slave_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NREG = 1 << AW;

  logic clk, rst_n;
  logic cs_n, as_n, rd_nwr, mst_own, mst_free;
  logic [AW-1:0] addr, reg_addr;
  logic [DW-1:0] wdata, rdata, reg_wdata, reg_rdata;
  logic start_ack_n, dsize_oe, rdata_oe, reg_wr_en, mst_yield_req;
  logic [1:0] dsize_ack_n;

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] exp_mem [NREG];
  int nvec, nerr;
  bit prev_hold;
  int seed_dummy;

  hostreg_slave #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .rd_nwr(rd_nwr),
    .addr(addr), .wdata(wdata), .start_ack_n(start_ack_n),
    .dsize_ack_n(dsize_ack_n), .dsize_oe(dsize_oe), .rdata(rdata),
    .rdata_oe(rdata_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_own(mst_own),
    .mst_free(mst_free), .mst_yield_req(mst_yield_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // register file model
  always @(posedge clk) if (reg_wr_en) rf[reg_addr] <= reg_wdata;
  assign reg_rdata = rf[reg_addr];

  function automatic logic [DW-1:0] init_word(input int i);
    return 16'hA000 ^ (i[15:0] * 16'h0101);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    nvec++;
    if (act !== exp_v) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic access(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit mst, input int ws, input bit hold_cs,
                        input bit cs_first, input bit after_gap);
    int rem;
    int lat;
    if (!after_gap) @(negedge clk);
    rd_nwr = rd; addr = a; wdata = d; cs_n = 1'b0; as_n = 1'b0; mst_own = mst;
    if (after_gap) begin
      @(posedge clk);
      @(negedge clk);
      check("R12 ignored after gap", start_ack_n, 1);
    end
    @(posedge clk);
    lat = 0;
    if (mst) begin
      rem = ws + 1 + $urandom_range(0, 2);
      for (int i = 0; i < rem; i++) begin
        @(negedge clk);
        if (i == 0) begin addr = ~a; rd_nwr = ~rd; end
        check("R4 yield held", mst_yield_req, 1);
        check("R4 ack waits", start_ack_n, 1);
        @(posedge clk); lat++;
      end
      @(negedge clk);
      mst_free = 1'b1; mst_own = 1'b0;
      @(posedge clk); lat++;
      @(negedge clk);
      mst_free = 1'b0;
      check("R4 yield dropped", mst_yield_req, 0);
      check("R4 ack one clk after free", start_ack_n, 1);
      @(posedge clk); lat++;
      check("R4 latency bound", (lat <= 5 + ws), 1);
      check("R4 latency exact", lat, rem + 2);
    end else begin
      @(negedge clk);
      addr = ~a; rd_nwr = ~rd;
      check("R3 ack not yet", start_ack_n, 1);
      @(posedge clk); lat++;
    end
    @(negedge clk);
    if (!mst) check(hold_cs ? "R11 ack latency" : "R3 ack latency", start_ack_n, 0);
    else      check("R4 ack low", start_ack_n, 0);
    check("R2 captured addr", reg_addr, a);
    check("R7 dsize not yet", dsize_ack_n, 2'b11);
    if (rd) begin
      check("R5 rdata_oe", rdata_oe, 1);
      check("R5 rdata", rdata, exp_mem[a]);
    end else check("R5 no rdata_oe on write", rdata_oe, 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 dsize one clk", dsize_ack_n, 2'b11);
    check("R6 write strobe", reg_wr_en, !rd);
    if (!rd) check("R6 wdata", reg_wdata, d);
    @(posedge clk);
    @(negedge clk);
    if (!rd) exp_mem[a] = d;
    check("R7 dsize low", dsize_ack_n, 2'b00);
    check("R7 dsize driven", dsize_oe, 1);
    check("R6 strobe single", reg_wr_en, 0);
    if (hold_cs) begin
      as_n = 1'b1; #1;
      check("R8 dsize off on as", dsize_ack_n, 2'b11);
      check("R9 rdata released", rdata_oe, 0);
    end else if (cs_first) begin
      cs_n = 1'b1; #1;
      check("R8 dsize off on cs", dsize_ack_n, 2'b11);
      check("R9 ack held until as", start_ack_n, 0);
      @(negedge clk);
      as_n = 1'b1; #1;
      check("R9 rdata released", rdata_oe, 0);
    end else begin
      as_n = 1'b1; cs_n = 1'b1; #1;
      check("R8 dsize off", dsize_ack_n, 2'b11);
      check("R9 rdata released", rdata_oe, 0);
    end
    @(posedge clk);
    @(negedge clk);
    check("R9 ack released", start_ack_n, 1);
    check("R9 dsize hiz", dsize_oe, 0);
    prev_hold = hold_cs;
  endtask

  initial begin
    nvec = 0; nerr = 0; prev_hold = 0;
    seed_dummy = $urandom(32'h5EED);
    for (int i = 0; i < NREG; i++) begin
      rf[i] = init_word(i);
      exp_mem[i] = init_word(i);
    end
    rst_n = 1'b0; cs_n = 1'b1; as_n = 1'b1; rd_nwr = 1'b1; addr = '0; wdata = '0;
    mst_own = 1'b0; mst_free = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ack reset", start_ack_n, 1);
    check("R1 dsize_oe reset", dsize_oe, 0);
    check("R1 rdata_oe reset", rdata_oe, 0);
    check("R1 wr reset", reg_wr_en, 0);
    check("R1 yield reset", mst_yield_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", start_ack_n, 1);

    // directed corners
    access(0, 4'h3, 16'hBEEF, 0, 0, 0, 0, 0);
    access(1, 4'h3, 16'h0,    0, 0, 0, 1, 0);
    access(1, 4'h7, 16'h0,    1, 0, 0, 0, 0);
    access(0, 4'h7, 16'h1234, 1, 3, 0, 0, 0);
    access(1, 4'h7, 16'h0,    0, 0, 0, 0, 1);
    access(0, 4'h9, 16'h5A5A, 0, 0, 1, 0, 0);
    access(1, 4'h9, 16'h0,    0, 0, 1, 0, 0);
    // R10: cs low with as high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 cs only", start_ack_n, 1);
      check("R10 cs only wr", reg_wr_en, 0);
    end
    access(1, 4'hF, 16'h0, 1, 2, 1, 0, 0);
    access(1, 4'h0, 16'h0, 0, 0, 0, 0, 0);
    // R10: as low with cs high
    @(negedge clk);
    cs_n = 1'b1; as_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 as only", start_ack_n, 1);
      check("R10 as only wr", reg_wr_en, 0);
    end
    as_n = 1'b1;
    prev_hold = 0;

    for (int n = 0; n < 300; n++) begin
      bit rd, mst, hold, csf, ag;
      int ws;
      rd   = $urandom_range(0, 1);
      mst  = ($urandom_range(0, 2) == 0);
      ws   = $urandom_range(0, 3);
      hold = ($urandom_range(0, 2) == 0);
      csf  = $urandom_range(0, 1);
      ag   = !prev_hold && ($urandom_range(0, 3) == 0);
      access(rd, AW'($urandom_range(0, NREG-1)), DW'($urandom), mst, ws, hold, csf, ag);
    end
    access(1, 4'h3, 16'h0, 0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule